// File: doc/BRIEF.md
# Redundant Clock Monitor Status Register with Interrupt

This block holds the read-only 8-bit status word of a clock generator that has several redundant reference inputs. It samples four clock-present flags, a PLL lock indication and a 2-bit code that names the active input. It keeps the clock flags sticky and raises an interrupt flag when something notable happens. Three kinds of event set the flag: a clock flag being newly captured, lock being lost, or the active-input code changing.

A host reads the word with a one-cycle read strobe. Every read clears the interrupt flag. The clock flags stay set until a separate sticky-clear pulse arrives. An interrupt-enable input gates the flag onto an active-high interrupt pin. All raw inputs pass through one register stage before any edge or change detection takes place.

Top module: `redund_stat_reg`

## Requirements
- R1: The read word is laid out as bit 7 interrupt flag, bits 6:3 sticky clock flags (bit 3+i for input i), bit 2 the registered lock level and bits 1:0 the registered active-input code.
- R2: A clock-flag input at 1 sets its sticky bit two clock edges after the input is driven. The bit stays 1 after the input returns to 0.
- R3: A one-cycle sticky-clear pulse zeroes every sticky clock bit whose input is 0, and it leaves the interrupt flag unchanged.
- R4: A sticky clock bit going from 0 to 1 sets the interrupt flag two edges after the input is driven.
- R5: Lock going from 1 to 0 sets the interrupt flag two edges later. Lock going from 0 to 1 does not set it.
- R6: Any change of the 2-bit active-input code sets the interrupt flag two edges later, and the new code appears in bits 1:0.
- R7: A read strobe clears the interrupt flag at the next edge. The flag then stays clear while the inputs are steady, because each transition is counted once.
- R8: When an event and a read strobe land on the same edge, the interrupt flag ends up set.
- R9: The interrupt pin equals the interrupt flag while the enable input is 1, and it is 0 while the enable is 0.
- R10: After reset the read word is 0 (with all inputs at 0) and the interrupt pin is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb_i | input | 1 | Read strobe; clears the interrupt flag |
| rd_data_o | output | 8 | Status word |
| clk_flag_i | input | 4 | Raw clock-present flags, one per input |
| lock_i | input | 1 | Raw PLL lock indication |
| sel_i | input | 2 | Raw active-input code |
| irq_en_i | input | 1 | Interrupt pin enable |
| sticky_clr_i | input | 1 | Clears the sticky clock flags |
| irq_o | output | 1 | Active-high interrupt pin |

## Verification
A status event and a read strobe can both act on the interrupt flag at the same clock edge. The bench changes the active-input code one cycle before it holds the read strobe high. This makes the detected change and the clearing read land on the same edge. Afterwards the flag is expected to read 1. A sticky-clear pulse while the flag is set is also checked, to confirm that it leaves the flag alone.

// File: rtl/redund_stat_reg.sv
module redund_stat_reg #(
  parameter int NCLK = 4,
  parameter int SELW = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_stb_i,
  output logic [NCLK+SELW+1:0]       rd_data_o,
  input  logic [NCLK-1:0]            clk_flag_i,
  input  logic                       lock_i,
  input  logic [SELW-1:0]            sel_i,
  input  logic                       irq_en_i,
  input  logic                       sticky_clr_i,
  output logic                       irq_o
);
  logic [NCLK-1:0] clk_q, clk_st;
  logic            lock_q, lock_d;
  logic [SELW-1:0] sel_q, sel_d;
  logic            arm0, arm, int_f;
  logic            ev_clk, ev_lock, ev_sel, ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q  <= '0;
      lock_q <= 1'b0;
      lock_d <= 1'b0;
      sel_q  <= '0;
      sel_d  <= '0;
      arm0   <= 1'b0;
      arm    <= 1'b0;
    end else begin
      clk_q  <= clk_flag_i;
      lock_q <= lock_i;
      lock_d <= lock_q;
      sel_q  <= sel_i;
      sel_d  <= sel_q;
      arm0   <= 1'b1;
      arm    <= arm0;
    end
  end

  // edge and change detection on registered copies
  assign ev_clk  = |(clk_q & ~clk_st);
  assign ev_lock = arm & lock_d & ~lock_q;
  assign ev_sel  = arm & (sel_q != sel_d);
  assign ev      = ev_clk | ev_lock | ev_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_st <= '0;
      int_f  <= 1'b0;
    end else begin
      clk_st <= (clk_st & ~{NCLK{sticky_clr_i}}) | clk_q;
      if (ev)            int_f <= 1'b1;
      else if (rd_stb_i) int_f <= 1'b0;
    end
  end

  assign rd_data_o = {int_f, clk_st, lock_q, sel_q};
  assign irq_o     = int_f & irq_en_i;

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sticky_clr_i |=> ((clk_st & $past(clk_st)) == $past(clk_st)));
  // R3
  sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_clr_i && clk_q == '0) |=> clk_st == '0);
  // R8
  event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> int_f);
  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && !ev) |=> !int_f);
  // R3
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_f && !rd_stb_i) |=> int_f);
  // R9
  pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> !irq_o);
endmodule

// File: tb/redund_stat_reg_bench.sv
module redund_stat_reg_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, rd_stb_i = 1'b0;
  logic [7:0] rd_data_o;
  logic [3:0] clk_flag_i = '0;
  logic       lock_i = 1'b0, irq_en_i = 1'b0, sticky_clr_i = 1'b0, irq_o;
  logic [1:0] sel_i = '0;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  redund_stat_reg u_redund_stat_reg (
    .clk(clk), .rst_n(rst_n), .rd_stb_i(rd_stb_i), .rd_data_o(rd_data_o),
    .clk_flag_i(clk_flag_i), .lock_i(lock_i), .sel_i(sel_i),
    .irq_en_i(irq_en_i), .sticky_clr_i(sticky_clr_i), .irq_o(irq_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(output logic [7:0] d);
    rd_stb_i = 1'b1;
    #1 d = rd_data_o;
    @(negedge clk);
    rd_stb_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 word", int'(rd_data_o), 0);
    chk("R10 pin", int'(irq_o), 0);
  endtask

  task automatic t_sticky;
    logic [7:0] d;
    clk_flag_i = 4'b0101;
    tick(2);
    chk("R2 sticky set", int'(rd_data_o[6:3]), 5);
    chk("R4 int on clk", int'(rd_data_o[7]), 1);
    chk("R1 layout", int'(rd_data_o), 8'hA8);
    clk_flag_i = 4'b0000;
    tick(3);
    chk("R2 sticky hold", int'(rd_data_o[6:3]), 5);
    do_read(d);
    chk("R7 read data", int'(d[7]), 1);
    chk("R7 cleared", int'(rd_data_o[7]), 0);
    tick(3);
    chk("R7 no retrigger", int'(rd_data_o[7]), 0);
  endtask

  task automatic t_clear;
    clk_flag_i = 4'b1000;
    tick(1);
    clk_flag_i = 4'b0000;
    tick(2);
    chk("R4 int on bit3", int'(rd_data_o[7]), 1);
    chk("R2 bit3 sticky", int'(rd_data_o[6:3]), 4'hD);
    sticky_clr_i = 1'b1;
    tick(1);
    sticky_clr_i = 1'b0;
    chk("R3 sticky cleared", int'(rd_data_o[6:3]), 0);
    chk("R3 int kept", int'(rd_data_o[7]), 1);
  endtask

  task automatic t_lock;
    logic [7:0] d;
    do_read(d);
    lock_i = 1'b1;
    tick(3);
    chk("R5 lock rise no int", int'(rd_data_o[7]), 0);
    chk("R1 lock bit", int'(rd_data_o[2]), 1);
    lock_i = 1'b0;
    tick(2);
    chk("R5 lock fall int", int'(rd_data_o[7]), 1);
  endtask

  task automatic t_sel;
    logic [7:0] d;
    do_read(d);
    sel_i = 2'b10;
    tick(2);
    chk("R6 sel int", int'(rd_data_o[7]), 1);
    chk("R6 sel value", int'(rd_data_o[1:0]), 2);
  endtask

  task automatic t_pin;
    irq_en_i = 1'b0;
    #1 chk("R9 pin masked", int'(irq_o), 0);
    irq_en_i = 1'b1;
    #1 chk("R9 pin on", int'(irq_o), 1);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    do_read(d);
    chk("R9 pin off after read", int'(irq_o), 0);
    sel_i = 2'b01;
    tick(1);
    do_read(d);
    chk("R8 set wins", int'(rd_data_o[7]), 1);
    chk("R8 pin", int'(irq_o), 1);
  endtask

  initial begin
    tick(2);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_sticky();
    t_clear();
    t_lock();
    t_sel();
    t_pin();
    t_collide();
    tick(2);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule